// File: doc/BRIEF.md
# AC-Driven Segment Display Driver

This block drives a bank of display segments and one common backplane electrode. No segment ever sees a DC voltage against the backplane. A polarity square wave comes in on `pol_in`, and the block registers it onto the backplane output. Each segment output carries the same square wave. It is inverted when the segment is lit and passed through unchanged when the segment is dark. The segment's state is therefore held only as its phase relative to the backplane. A backlight output is driven the same way from its own enable bit.

New patterns arrive serially. Each cycle with `shift_en` high moves `ser_din` into a shift chain built from `N_SECT` cascaded sections of `SECT_W` bits each, 64 bits by default. The last stage appears on `ser_dout` so that further sections can be added downstream. The visible pattern stays unchanged while bits are shifted. A single cycle of `load_stb` copies the whole chain, together with `bl_on`, into the display register. All outputs then change at the same clock edge.

Top module: `ac_seg_drv`

## Requirements
- R1: While `rst_n` is low, and on the first edge after its release, `seg_out`, `bp_out`, `bl_out` and `ser_dout` are all 0. Chain and display register are cleared, so every segment is dark.
- R2: A clock edge with `shift_en` high moves every chain bit one place toward the serial output and puts `ser_din` into stage 0. After 64 shifts, the bit entered by the first of them drives segment 63 and the bit entered by the last drives segment 0.
- R3: `ser_dout` equals the last chain stage (stage 63). After k further shifts it presents the bit that was entered 64 shifts earlier.
- R4: Without a `load_stb` pulse, shifting has no effect on `seg_out` or `bl_out` relative to `bp_out`.
- R5: The edge at which `load_stb` is high sets all 64 segments and the backlight to the new pattern together. It is visible right after that edge.
- R6: A lit segment (display bit 1) drives `seg_out[i] = ~bp_out`. A dark segment (bit 0) drives `seg_out[i] = bp_out`.
- R7: `bp_out` equals `pol_in` as sampled at the previous clock edge.
- R8: `bl_on` is captured only at a `load_stb` edge. When captured high, `bl_out = ~bp_out`, otherwise `bl_out = bp_out`. Changing `bl_on` without a strobe has no effect.
- R9: If `load_stb` and `shift_en` are high in the same cycle, the display register takes the chain contents from before that cycle's shift.
- R10: With `pol_in` steady and no strobe, every output holds its value from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_din | input | 1 | Serial segment data |
| shift_en | input | 1 | Shift the chain one place this cycle |
| load_stb | input | 1 | Copy chain and backlight enable to display register |
| bl_on | input | 1 | Backlight enable, captured on strobe |
| pol_in | input | 1 | Polarity square wave |
| seg_out | output | 64 | Segment drive waveforms |
| bp_out | output | 1 | Backplane drive waveform |
| bl_out | output | 1 | Backlight drive waveform |
| ser_dout | output | 1 | Last chain stage, for cascading |

## Verification
Shifting and loading can fall on the same edge. The bench first loads a known pattern into the chain, then raises `shift_en` and `load_stb` in one cycle with a fresh serial bit. The display must show the pre-shift pattern, with no trace of the new bit. A second, lone strobe must then show the pattern moved by one place with the new bit in segment 0. A polarity edge falling on the same edge as a strobe is judged the same way: the new pattern must appear already re-phased against the new backplane level.

// File: rtl/ac_seg_pkg.sv
package ac_seg_pkg;
   localparam int unsigned DEF_SECT_W = 32;
   localparam int unsigned DEF_N_SECT = 2;

   // drive level for one electrode: in phase when off, inverted when on
   function automatic logic phase_of(input logic pol, input logic on);
      return pol ^ on;
   endfunction
endpackage

// File: rtl/seg_shift_sect.sv
module seg_shift_sect #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         sin,
   output logic [W-1:0] q,
   output logic         sout
);
   always_ff @(posedge clk) begin
      if (!rst_n)        q <= '0;
      else if (shift_en) q <= {q[W-2:0], sin};
   end

   assign sout = q[W-1];
endmodule

// File: rtl/seg_hold_reg.sv
module seg_hold_reg #(
   parameter int unsigned W = 65
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/seg_phase_drv.sv
module seg_phase_drv
   import ac_seg_pkg::*;
#(
   parameter int unsigned W = 65
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pol,
   input  logic [W-1:0] pat,
   output logic [W-1:0] drv,
   output logic         bp
);
   always_ff @(posedge clk) begin
      if (!rst_n) bp <= 1'b0;
      else        bp <= pol;
   end

   for (genvar i = 0; i < W; i++) begin : g_elec
      always_ff @(posedge clk) begin
         if (!rst_n) drv[i] <= 1'b0;
         else        drv[i] <= phase_of(pol, pat[i]);
      end
   end
endmodule

// File: rtl/ac_seg_drv.sv
module ac_seg_drv
   import ac_seg_pkg::*;
#(
   parameter int unsigned SECT_W = DEF_SECT_W,
   parameter int unsigned N_SECT = DEF_N_SECT
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ser_din,
   input  logic                       shift_en,
   input  logic                       load_stb,
   input  logic                       bl_on,
   input  logic                       pol_in,
   output logic [SECT_W*N_SECT-1:0]   seg_out,
   output logic                       bp_out,
   output logic                       bl_out,
   output logic                       ser_dout
);
   localparam int unsigned CHAIN_W = SECT_W * N_SECT;
   localparam int unsigned DISP_W  = CHAIN_W + 1;

   initial begin
      if (SECT_W < 2) $fatal(1, "SECT_W must be at least 2");
      if (N_SECT < 1) $fatal(1, "N_SECT must be at least 1");
   end

   logic [CHAIN_W-1:0] chain_q;
   logic [N_SECT:0]    link;
   logic [DISP_W-1:0]  hold_q;
   logic [DISP_W-1:0]  pat_nxt;
   logic [DISP_W-1:0]  drv_q;

   assign link[0] = ser_din;

   for (genvar s = 0; s < N_SECT; s++) begin : g_sect
      seg_shift_sect #(.W(SECT_W)) u_sect (
         .clk      (clk),
         .rst_n    (rst_n),
         .shift_en (shift_en),
         .sin      (link[s]),
         .q        (chain_q[s*SECT_W +: SECT_W]),
         .sout     (link[s+1])
      );
   end

   assign ser_dout = link[N_SECT];

   // strobe sees the chain before this edge's shift
   assign pat_nxt = load_stb ? {bl_on, chain_q} : hold_q;

   seg_hold_reg #(.W(DISP_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_stb),
      .d     ({bl_on, chain_q}),
      .q     (hold_q)
   );

   seg_phase_drv #(.W(DISP_W)) u_drv (
      .clk   (clk),
      .rst_n (rst_n),
      .pol   (pol_in),
      .pat   (pat_nxt),
      .drv   (drv_q),
      .bp    (bp_out)
   );

   assign seg_out = drv_q[CHAIN_W-1:0];
   assign bl_out  = drv_q[CHAIN_W];
endmodule

// File: rtl/ac_seg_drv_chk.sv
module ac_seg_drv_chk #(
   parameter int unsigned CHAIN_W = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ser_din,
   input logic               shift_en,
   input logic               load_stb,
   input logic               bl_on,
   input logic               pol_in,
   input logic [CHAIN_W-1:0] seg_out,
   input logic               bp_out,
   input logic               bl_out,
   input logic [CHAIN_W-1:0] chain_q
);
   wire [CHAIN_W-1:0] shown = seg_out ^ {CHAIN_W{bp_out}};

   assert_bp_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> bp_out == $past(pol_in));

   assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> chain_q[0] == $past(ser_din));

   assert_hold_while_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_stb && rst_n) ##1 !load_stb |=> shown == $past(shown));

   assert_load_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> shown == $past(chain_q));

   assert_backlight_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> (bl_out ^ bp_out) == $past(bl_on));

   assert_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_stb ##1 (!load_stb && $stable(pol_in))) |=> $stable(seg_out) && $stable(bl_out));
endmodule

bind ac_seg_drv ac_seg_drv_chk #(.CHAIN_W(CHAIN_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ser_din  (ser_din),
   .shift_en (shift_en),
   .load_stb (load_stb),
   .bl_on    (bl_on),
   .pol_in   (pol_in),
   .seg_out  (seg_out),
   .bp_out   (bp_out),
   .bl_out   (bl_out),
   .chain_q  (chain_q)
);

// File: tb/tb_ac_seg_drv.sv
module tb_ac_seg_drv;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_din = 1'b0, shift_en = 1'b0, load_stb = 1'b0, bl_on = 1'b0, pol_in = 1'b0;
   logic [63:0] seg_out;
   logic        bp_out, bl_out, ser_dout;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   logic [63:0] exp_pat = '0;
   logic        exp_bl = 1'b0;
   logic        exp_pol = 1'b0;

   always #5 clk = ~clk;

   ac_seg_drv dut (
      .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .shift_en(shift_en),
      .load_stb(load_stb), .bl_on(bl_on), .pol_in(pol_in),
      .seg_out(seg_out), .bp_out(bp_out), .bl_out(bl_out), .ser_dout(ser_dout)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk1(string tag, logic act, logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
      end
   endtask

   task automatic chk_out(string tag);
      logic [63:0] es;
      es = exp_pat ^ {64{exp_pol}};
      n_run++;
      if (seg_out !== es || bp_out !== exp_pol || bl_out !== (exp_bl ^ exp_pol)) begin
         n_fail++;
         $display("FAIL %s seg=%h bp=%0b bl=%0b exp seg=%h bp=%0b bl=%0b",
                  tag, seg_out, bp_out, bl_out, es, exp_pol, exp_bl ^ exp_pol);
      end
   endtask

   task automatic shift_vec(logic [63:0] v);
      for (int i = 0; i < 64; i++) begin
         ser_din = v[63-i];
         shift_en = 1'b1;
         step();
      end
      shift_en = 1'b0;
   endtask

   task automatic strobe(logic [63:0] v, logic b);
      load_stb = 1'b1;
      bl_on = b;
      step();
      load_stb = 1'b0;
      exp_pat = v;
      exp_bl = b;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      pol_in = 1'b1;
      step(); step();
      chk_out("R1 in reset");
      chk1("R1 ser_dout reset", ser_dout, 1'b0);
      pol_in = 1'b0;
      rst_n = 1'b1;
      step();
      exp_pol = 1'b0;
      chk_out("R1 after release");
   endtask

   task automatic t_load_phase();
      logic [63:0] a = 64'hA5C3_0F1E_8001_7FFE;
      shift_vec(a);
      chk_out("R4 pattern hidden during shift");
      chk1("R3 ser_dout first bit", ser_dout, a[63]);
      strobe(a, 1'b0);
      chk_out("R5 R2 strobe shows chain, pol low");
      pol_in = 1'b1;
      step();
      exp_pol = 1'b1;
      chk_out("R6 R7 pol high phase");
      step();
      chk_out("R10 steady pol");
      pol_in = 1'b0;
      step();
      exp_pol = 1'b0;
      chk_out("R6 R7 pol back low");
   endtask

   task automatic t_shift_hold();
      logic [63:0] a = 64'hA5C3_0F1E_8001_7FFE;
      logic [63:0] b = 64'h1234_5678_9ABC_DEF0;
      ser_din = b[63];
      shift_en = 1'b1;
      step();
      shift_en = 1'b0;
      chk1("R3 ser_dout after one shift", ser_dout, a[62]);
      chk_out("R4 one shift no strobe");
      for (int i = 1; i < 64; i++) begin
         ser_din = b[63-i];
         shift_en = 1'b1;
         step();
      end
      shift_en = 1'b0;
      chk_out("R4 full shift no strobe");
      chk1("R3 ser_dout new first bit", ser_dout, b[63]);
      pol_in = 1'b1;
      strobe(b, 1'b0);
      exp_pol = 1'b1;
      chk_out("R5 strobe with polarity edge");
   endtask

   task automatic t_same_cycle();
      logic [63:0] b = 64'h1234_5678_9ABC_DEF0;
      ser_din = 1'b1;
      shift_en = 1'b1;
      load_stb = 1'b1;
      step();
      shift_en = 1'b0;
      load_stb = 1'b0;
      exp_pat = b;
      chk_out("R9 strobe+shift shows pre-shift");
      strobe({b[62:0], 1'b1}, 1'b0);
      chk_out("R9 later strobe shows shifted");
   endtask

   task automatic t_backlight();
      bl_on = 1'b1;
      step();
      chk_out("R8 bl_on ignored without strobe");
      strobe(exp_pat, 1'b1);
      chk_out("R8 backlight lit");
      pol_in = 1'b0;
      step();
      exp_pol = 1'b0;
      chk_out("R8 backlight follows polarity");
      bl_on = 1'b0;
      step();
      chk_out("R8 bl_on drop ignored");
   endtask

   task automatic t_extremes();
      shift_vec('1);
      strobe('1, 1'b0);
      chk_out("R6 all lit");
      shift_vec('0);
      chk_out("R4 all lit kept while zeros shift");
      strobe('0, 1'b0);
      chk_out("R6 all dark");
      pol_in = 1'b1;
      step();
      exp_pol = 1'b1;
      chk_out("R6 all dark pol high");
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_load_phase();
      t_shift_hold();
      t_same_cycle();
      t_backlight();
      t_extremes();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule